// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block connects a fast 12-bit port (A) to a slower 24-bit port (B). The B port has two 12-bit halves, called 1B and 2B. Going from A to B, two 12-bit words that arrive one after the other on A are packed into one 24-bit word. The earlier word goes to the 1B half and the later word to the 2B half. To do this, the 1B path has two register stages and the 2B path has one. Going from B to A, each half is captured in its own register, and a half-select picks which captured half drives A. Every data register has its own active-low load enable.

Port direction is controlled by a small state machine. Each clock edge it samples the two active-low output enables. It has four states: `DIR_OFF` (neither port drives), `DIR_A` (A drives), `DIR_B` (B drives) and `DIR_BOTH`. Any state can move to any other on one edge. The transitions are named after the next state: *to-off*, *to-A*, *to-B* and *to-both*. The half-select is also registered, so a change of data direction or source only appears after a rising clock edge.

Tri-state pads are modelled as a data output plus an active-high drive flag for each port. The data outputs always carry the register contents; the drive flag says whether the pad would be driven.

Top module: `nw_bus_exchanger`

## Requirements
- R1: A synchronous active-high `rst` sets to zero all of the following on the clock edge where it is sampled high: the two 1B stages, the 2B register, both B-to-A registers and the registered select. It also puts the direction machine in `DIR_OFF` (`a_drv`=0, `b_drv`=0).
- R2: A data register loads only at a rising edge where its own enable is sampled low. While an enable is high, the register and the outputs it feeds keep their value, whatever the data inputs do.
- R3: The path to `b1_out` has two stages. `ld_a1_n` low loads `a_in` into stage one. `ld_a2_n` low copies stage one's value from before the edge into stage two, which drives `b1_out`. A word captured by `ld_a1_n` alone therefore does not reach `b1_out` on that edge.
- R4: The path to `b2_out` has one stage. At an edge where `ld_a2_n` is low, `b2_out` takes `a_in`.
- R5: If word X is loaded with `ld_a1_n` low at one edge, and word Y is presented with `ld_a2_n` low at the next edge, then after that edge `{b2_out, b1_out}` = {Y, X}. The earlier word sits in the 1B half (bits 11:0).
- R6: The B-to-A direction has two registers. One loads `b1_in` when `ld_b1_n` is low; the other loads `b2_in` when `ld_b2_n` is low.
- R7: When the registered select is 0, `a_out` shows the 1B capture register; when it is 1, `a_out` shows the 2B capture register.
- R8: The output enables are active low. `a_drv` is 1 only when the registered `oe_a_n` is 0. `b_drv` is 1 only when the registered `oe_b_n` is 0.
- R9: `sel`, `oe_a_n` and `oe_b_n` reach the outputs only after the next rising edge. Between edges, a change on any of them leaves `a_out`, `a_drv` and `b_drv` unchanged.
- R10: The state encoding is {B drives, A drives}: `DIR_OFF`=00, `DIR_A`=01, `DIR_B`=10, `DIR_BOTH`=11. Every edge not in reset loads the state selected by the sampled enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers use the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 12 | Data arriving on port A |
| ld_a1_n | input | 1 | Active-low load for the first 1B stage |
| ld_a2_n | input | 1 | Active-low load for the 2B register and the second 1B stage |
| b1_in | input | 12 | Data arriving on the 1B half |
| b2_in | input | 12 | Data arriving on the 2B half |
| ld_b1_n | input | 1 | Active-low load for the 1B capture register |
| ld_b2_n | input | 1 | Active-low load for the 2B capture register |
| sel | input | 1 | Half-select for A outputs (0 = 1B, 1 = 2B), registered |
| oe_a_n | input | 1 | Active-low output enable for port A, registered |
| oe_b_n | input | 1 | Active-low output enable for port B, registered |
| a_out | output | 12 | Data toward port A |
| a_drv | output | 1 | Port A pads driven when 1 |
| b1_out | output | 12 | Data toward the 1B half |
| b2_out | output | 12 | Data toward the 2B half |
| b_drv | output | 1 | Port B pads driven when 1 |

## Verification
A wrong direction state appears on `a_drv` and `b_drv` one edge after the enables are sampled. Bad packing shows up differently: a wrong or swapped 1B stage appears on `b1_out` only at the next `ld_a2_n` edge, so the bench follows every such edge with a compare. A bad capture register or select stays invisible on `a_out` until the select points at it. The random traffic therefore toggles `sel` often, so that both registers are exposed within a few cycles.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
    typedef enum logic [1:0] {
        DIR_OFF  = 2'b00,
        DIR_A    = 2'b01,
        DIR_B    = 2'b10,
        DIR_BOTH = 2'b11
    } dir_e;
endpackage

// File: rtl/xchg_dir_ctrl.sv
module xchg_dir_ctrl
    import xchg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic oe_a_n,
    input  logic oe_b_n,
    output logic sel_q,
    output logic drv_a,
    output logic drv_b
);
    dir_e state_q, state_d;

    // next state: named after the target (to-off, to-A, to-B, to-both)
    always_comb begin
        unique case ({oe_b_n, oe_a_n})
            2'b11:   state_d = DIR_OFF;
            2'b10:   state_d = DIR_A;
            2'b01:   state_d = DIR_B;
            default: state_d = DIR_BOTH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIR_OFF;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel;
        end
    end

    always_comb begin
        unique case (state_q)
            DIR_OFF:  begin drv_a = 1'b0; drv_b = 1'b0; end
            DIR_A:    begin drv_a = 1'b1; drv_b = 1'b0; end
            DIR_B:    begin drv_a = 1'b0; drv_b = 1'b1; end
            DIR_BOTH: begin drv_a = 1'b1; drv_b = 1'b1; end
            default:  begin drv_a = 1'b0; drv_b = 1'b0; end
        endcase
    end

    // R8 / R9: enables act one edge later, never earlier
    p_a_on_r8: assert property (@(posedge clk) disable iff (rst)
        !oe_a_n |=> drv_a);
    p_a_off_r9: assert property (@(posedge clk) disable iff (rst)
        oe_a_n |=> !drv_a);
    p_b_on_r8: assert property (@(posedge clk) disable iff (rst)
        !oe_b_n |=> drv_b);
    p_sel_lag_r9: assert property (@(posedge clk) disable iff (rst)
        sel |=> sel_q);
    p_reset_off_r1: assert property (@(posedge clk)
        rst |=> (!drv_a && !drv_b && !sel_q));
endmodule

// File: rtl/xchg_pack.sv
module xchg_pack #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] a_in,
    input  logic              ld1_n,
    input  logic              ld2_n,
    output logic [WORD_W-1:0] hi_half_lo,
    output logic [WORD_W-1:0] hi_half_hi
);
    logic [WORD_W-1:0] stage1_q, stage2_q, single_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
            single_q <= '0;
        end else begin
            if (!ld1_n) stage1_q <= a_in;
            if (!ld2_n) begin
                stage2_q <= stage1_q;
                single_q <= a_in;
            end
        end
    end

    assign hi_half_lo = stage2_q;
    assign hi_half_hi = single_q;

    p_two_stage_r3: assert property (@(posedge clk) disable iff (rst)
        !ld2_n |=> hi_half_lo == $past(stage1_q));
    p_one_stage_r4: assert property (@(posedge clk) disable iff (rst)
        !ld2_n |=> hi_half_hi == $past(a_in));
    p_hold_b_r2: assert property (@(posedge clk) disable iff (rst)
        ld2_n |=> ($stable(hi_half_lo) && $stable(hi_half_hi)));
endmodule

// File: rtl/xchg_unpack.sv
module xchg_unpack #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] b1_in,
    input  logic [WORD_W-1:0] b2_in,
    input  logic              ld1_n,
    input  logic              ld2_n,
    input  logic              sel_q,
    output logic [WORD_W-1:0] a_out
);
    localparam int HALVES = 2;
    logic [WORD_W-1:0] cap_q [HALVES];
    logic [WORD_W-1:0] src   [HALVES];
    logic [HALVES-1:0] ld_n;

    assign src[0] = b1_in;
    assign src[1] = b2_in;
    assign ld_n   = {ld2_n, ld1_n};

    for (genvar h = 0; h < HALVES; h++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst)           cap_q[h] <= '0;
            else if (!ld_n[h]) cap_q[h] <= src[h];
        end
    end

    assign a_out = sel_q ? cap_q[1] : cap_q[0];

    p_cap1_r6: assert property (@(posedge clk) disable iff (rst)
        !ld1_n |=> cap_q[0] == $past(b1_in));
    p_cap2_r6: assert property (@(posedge clk) disable iff (rst)
        !ld2_n |=> cap_q[1] == $past(b2_in));
    p_hold_a_r2: assert property (@(posedge clk) disable iff (rst)
        (ld1_n && ld2_n) |=> ($stable(cap_q[0]) && $stable(cap_q[1])));
endmodule

// File: rtl/nw_bus_exchanger.sv
module nw_bus_exchanger #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] a_in,
    input  logic              ld_a1_n,
    input  logic              ld_a2_n,
    input  logic [WORD_W-1:0] b1_in,
    input  logic [WORD_W-1:0] b2_in,
    input  logic              ld_b1_n,
    input  logic              ld_b2_n,
    input  logic              sel,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    output logic [WORD_W-1:0] a_out,
    output logic              a_drv,
    output logic [WORD_W-1:0] b1_out,
    output logic [WORD_W-1:0] b2_out,
    output logic              b_drv
);
    logic sel_q;

    xchg_dir_ctrl u_dir (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .sel_q  (sel_q),
        .drv_a  (a_drv),
        .drv_b  (b_drv)
    );

    xchg_pack #(.WORD_W(WORD_W)) u_pack (
        .clk        (clk),
        .rst        (rst),
        .a_in       (a_in),
        .ld1_n      (ld_a1_n),
        .ld2_n      (ld_a2_n),
        .hi_half_lo (b1_out),
        .hi_half_hi (b2_out)
    );

    xchg_unpack #(.WORD_W(WORD_W)) u_unpack (
        .clk   (clk),
        .rst   (rst),
        .b1_in (b1_in),
        .b2_in (b2_in),
        .ld1_n (ld_b1_n),
        .ld2_n (ld_b2_n),
        .sel_q (sel_q),
        .a_out (a_out)
    );

    // R5: back-to-back loads leave the earlier word in the 1B half
    p_pack_order_r5: assert property (@(posedge clk) disable iff (rst)
        (!ld_a1_n && ld_a2_n) ##1 (!ld_a2_n && ld_a1_n)
        |=> (b1_out == $past(a_in, 2) && b2_out == $past(a_in)));
endmodule

// File: tb/sim_nw_bus_exchanger.sv
module sim_nw_bus_exchanger;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic         ld_a1_n = 1'b1, ld_a2_n = 1'b1, ld_b1_n = 1'b1, ld_b2_n = 1'b1;
    logic         sel = 1'b0, oe_a_n = 1'b1, oe_b_n = 1'b1;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_drv, b_drv;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state, derived from the requirements
    logic [W-1:0] m_s1, m_s2, m_r2, m_u1, m_u2;
    logic         m_sel, m_da, m_db;

    always #10 clk = ~clk;

    nw_bus_exchanger #(.WORD_W(W)) u0 (
        .clk(clk), .rst(rst), .a_in(a_in), .ld_a1_n(ld_a1_n), .ld_a2_n(ld_a2_n),
        .b1_in(b1_in), .b2_in(b2_in), .ld_b1_n(ld_b1_n), .ld_b2_n(ld_b2_n),
        .sel(sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .a_out(a_out), .a_drv(a_drv), .b1_out(b1_out), .b2_out(b2_out), .b_drv(b_drv)
    );

    function automatic logic [W-1:0] exp_a_out();
        return m_sel ? m_u2 : m_u1;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_r2 = '0; m_u1 = '0; m_u2 = '0;
            m_sel = 1'b0; m_da = 1'b0; m_db = 1'b0;
        end else begin
            if (!ld_a2_n) begin m_s2 = m_s1; m_r2 = a_in; end
            if (!ld_a1_n) m_s1 = a_in;
            if (!ld_b1_n) m_u1 = b1_in;
            if (!ld_b2_n) m_u2 = b2_in;
            m_sel = sel; m_da = !oe_a_n; m_db = !oe_b_n;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
    endtask

    task automatic check_all(string tag);
        chk({tag, " R3 b1_out"}, 32'(b1_out), 32'(m_s2));
        chk({tag, " R4 b2_out"}, 32'(b2_out), 32'(m_r2));
        chk({tag, " R7 a_out"},  32'(a_out),  32'(exp_a_out()));
        chk({tag, " R8 a_drv"},  32'(a_drv),  32'(m_da));
        chk({tag, " R8 b_drv"},  32'(b_drv),  32'(m_db));
    endtask

    task automatic idle_loads();
        ld_a1_n = 1'b1; ld_a2_n = 1'b1; ld_b1_n = 1'b1; ld_b2_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        tick(); tick();
        // R1: reset state
        check_all("R1 reset");
        rst = 1'b0;
        tick();

        // R3 / R5: packing
        a_in = 12'hABC; ld_a1_n = 1'b0;
        tick();
        chk("R3 first word not yet on b1_out", 32'(b1_out), 32'h0);
        a_in = 12'h123; ld_a1_n = 1'b1; ld_a2_n = 1'b0;
        tick();
        chk("R5 earlier word in 1B half", 32'(b1_out), 32'hABC);
        chk("R5 later word in 2B half", 32'(b2_out), 32'h123);

        // R2: enables high -> hold
        idle_loads(); a_in = 12'hFFF; b1_in = 12'h777; b2_in = 12'h888;
        tick();
        chk("R2 b1_out held", 32'(b1_out), 32'hABC);
        chk("R2 b2_out held", 32'(b2_out), 32'h123);
        chk("R2 a_out held", 32'(a_out), 32'h0);

        // R9: select/enable change invisible until edge
        sel = 1'b1; oe_a_n = 1'b0;
        b1_in = 12'h5A5; b2_in = 12'h3C3; ld_b1_n = 1'b0; ld_b2_n = 1'b0;
        #5;
        chk("R9 a_drv before edge", 32'(a_drv), 32'h0);
        chk("R9 a_out before edge", 32'(a_out), 32'h0);
        tick();
        chk("R8 a_drv after edge", 32'(a_drv), 32'h1);
        chk("R6 R7 a_out shows 2B capture", 32'(a_out), 32'h3C3);
        idle_loads(); sel = 1'b0;
        #5;
        chk("R9 sel change before edge", 32'(a_out), 32'h3C3);
        tick();
        chk("R7 a_out shows 1B capture", 32'(a_out), 32'h5A5);

        // R10: all four direction states
        for (int k = 0; k < 4; k++) begin
            oe_a_n = !k[0]; oe_b_n = !k[1];
            tick();
            chk("R10 state bit A", 32'(a_drv), 32'(k[0]));
            chk("R10 state bit B", 32'(b_drv), 32'(k[1]));
        end

        // random traffic with occasional reset (R1..R10)
        for (int i = 0; i < 600; i++) begin
            a_in    = W'($urandom); b1_in = W'($urandom); b2_in = W'($urandom);
            ld_a1_n = $urandom % 2 == 0; ld_a2_n = $urandom % 2 == 0;
            ld_b1_n = $urandom % 3 == 0; ld_b2_n = $urandom % 3 == 0;
            sel     = 1'($urandom); oe_a_n = 1'($urandom); oe_b_n = 1'($urandom);
            rst     = ($urandom % 50) == 0;
            tick();
            check_all("rand");
        end
        rst = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule